// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs complete operations on an 8-bit asynchronous NAND flash bus. A host hands it one request at a time: a chip reset, an identifier read, a page read, a page program or a block erase. Each request carries a linear byte address, a flag selecting the spare area and a byte count. The sequencer then drives the latch-enable lines, the write and read strobes, chip enable and the data bus. It produces every opcode, address and data cycle, waits out the post-confirm delay and, for program and erase, polls the device status until the device is ready.

The linear address is divided into column and row by a column-width input C. Setting the spare flag moves the column into the spare area by adding 2^C. Program data comes in on a valid/ready byte stream and read data goes out on another. Strobe low and high widths and the post-confirm delay are given in clock cycles. The host sees `busy` for the length of an operation, followed by a single-cycle `done` that carries the pass/fail outcome.

Top module: `nand_seq`

## Requirements
- R1: Operation code 0 (reset) produces a single command cycle with byte 0xFF and no address or data cycles. It then completes with `fail` = 0.
- R2: Operation code 1 (identifier read) sends command 0x90 and one address cycle of 0x00. It then reads five bytes and delivers them in order on the read stream.
- R3: The column is (address mod 2^C), plus 2^C when the spare flag is set. The row is address >> C. A five-cycle address sends column[7:0], column[15:8], row[7:0], row[15:8], row[23:16], in that order.
- R4: Operation code 2 (page read) sends command 0x00, the five address cycles and confirm 0x30. It then reads the requested number of bytes (zero allowed) and delivers each on the read stream, holding `rd_data` steady while `rd_ready` is low.
- R5: Operation code 3 (page program) sends command 0x80, the five address cycles, then the requested number of bytes taken in order from the write stream, then confirm 0x10.
- R6: Operation code 4 (block erase) sends command 0x60, three row address cycles (row[7:0], row[15:8], row[23:16]) and confirm 0xD0.
- R7: After a program or erase confirm, the block repeats command 0x70 followed by a one-byte read until bit 5 of that byte is 1. `fail` then equals bit 0 of that last status byte.
- R8: After any confirm byte (0x30, 0x10 or 0xD0), at least `cfg_t_wb` clock cycles pass before the next strobe falls.
- R9: The command latch line is high only during command cycles and the address latch line only during address cycles, never both together. The write and read strobes are never both low. The bus is never driven while the read strobe is low.
- R10: Every write or read strobe stays low for exactly max(`cfg_t_lo`,1) clocks and then high for at least max(`cfg_t_hi`,1) clocks.
- R11: `busy` is high from acceptance until `done`, and `done` lasts one cycle. A request that arrives while busy is ignored, and so is any operation code from 5 to 7.
- R12: During and right after reset, chip enable, write strobe and read strobe are high, both latch lines are low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Operation code (0..4) |
| req_addr | input | ADDR_W | Linear byte address |
| req_spare | input | 1 | Select spare area |
| req_len | input | LEN_W | Byte count for page read or program |
| cfg_col_bits | input | 4 | Column width C |
| cfg_t_lo | input | TW | Strobe low width in clocks |
| cfg_t_hi | input | TW | Strobe high width in clocks |
| cfg_t_wb | input | WBW | Post-confirm delay in clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Outcome, valid with done |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte valid |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte accepted |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |

## Verification
The assertions rely on two things: the timing and column-width inputs stay unchanged for the whole of an operation, and the status byte returned by the device eventually sets its ready bit. The bench changes configuration only between operations, while `busy` is low. Its device model reports not-ready a bounded number of times, from zero to three, and then reports ready. The bench also applies random valid and ready throttling on both byte streams, so the assertions see streams stalled at arbitrary points.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_RDID  = 3'd1,
    OP_PREAD = 3'd2,
    OP_PROG  = 3'd3,
    OP_ERASE = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT,
    S_RDATA, S_RDOUT, S_STCMD, S_STRD, S_DONE
  } seq_st_e;

  localparam logic [7:0] OPC_RESET  = 8'hFF;
  localparam logic [7:0] OPC_RDID   = 8'h90;
  localparam logic [7:0] OPC_PREAD  = 8'h00;
  localparam logic [7:0] OPC_PREAD2 = 8'h30;
  localparam logic [7:0] OPC_PROG   = 8'h80;
  localparam logic [7:0] OPC_PROG2  = 8'h10;
  localparam logic [7:0] OPC_ERASE  = 8'h60;
  localparam logic [7:0] OPC_ERASE2 = 8'hD0;
  localparam logic [7:0] OPC_STATUS = 8'h70;

  localparam int RDY_BIT  = 5;
  localparam int FAIL_BIT = 0;
  localparam int ID_BYTES = 5;
  localparam int N_ACYC   = 5;

endpackage

// File: rtl/nand_addr_form.sv
module nand_addr_form #(
  parameter int ADDR_W = 32,
  parameter int CBW    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              spare,
  input  logic [CBW-1:0]    col_bits,
  output logic [4:0][7:0]   cyc_bytes
);
  localparam int COL_W = 16;
  localparam int ROW_W = 24;

  logic [ADDR_W-1:0] unit;
  logic [ADDR_W-1:0] col_full;
  logic [ADDR_W-1:0] row_full;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;

  assign unit     = ADDR_W'(1) << col_bits;
  assign col_full = (addr & (unit - ADDR_W'(1))) + (spare ? unit : '0);
  assign row_full = addr >> col_bits;
  assign col      = COL_W'(col_full);
  assign row      = ROW_W'(row_full);

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_col
      assign cyc_bytes[g] = col[8*g +: 8];
    end
    for (g = 0; g < 3; g++) begin : g_row
      assign cyc_bytes[g+2] = row[8*g +: 8];
    end
  endgenerate

endmodule

// File: rtl/nand_bus_cyc.sv
module nand_bus_cyc
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cyc_kind_e     kind,
  input  logic [7:0]    wbyte,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  input  logic [7:0]    dq_i,
  output logic          idle,
  output logic          fin,
  output logic [7:0]    rbyte,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_o,
  output logic          dq_oe
);
  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} est_e;

  est_e          st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  cyc_kind_e     kind_q;
  logic [7:0]    byte_q, rbyte_q;
  logic [TW-1:0] lo_len, hi_len;
  logic          load, cap;

  assign lo_len = (t_lo == '0) ? TW'(1) : t_lo;
  assign hi_len = (t_hi == '0) ? TW'(1) : t_hi;
  assign load   = (st_q == E_IDLE) && start;
  assign cap    = (st_q == E_LOW) && (cnt_q == '0) && (kind_q == K_RD);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      E_IDLE: if (start) begin
        st_d  = E_LOW;
        cnt_d = lo_len - TW'(1);
      end
      E_LOW: if (cnt_q == '0) begin
        st_d  = E_HIGH;
        cnt_d = hi_len - TW'(1);
      end else cnt_d = cnt_q - TW'(1);
      E_HIGH: if (cnt_q == '0) st_d = E_IDLE;
              else cnt_d = cnt_q - TW'(1);
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_CMD;
      byte_q  <= '0;
      rbyte_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (load) begin
        kind_q <= kind;
        byte_q <= wbyte;
      end
      if (cap) rbyte_q <= dq_i;
    end
  end

  assign idle  = (st_q == E_IDLE);
  assign fin   = (st_q == E_HIGH) && (cnt_q == '0);
  assign rbyte = rbyte_q;
  assign cle   = (st_q != E_IDLE) && (kind_q == K_CMD);
  assign ale   = (st_q != E_IDLE) && (kind_q == K_ADDR);
  assign we_n  = !((st_q == E_LOW) && (kind_q != K_RD));
  assign re_n  = !((st_q == E_LOW) && (kind_q == K_RD));
  assign dq_o  = byte_q;
  assign dq_oe = (st_q != E_IDLE) && (kind_q != K_RD);

  // R9
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R9
  drive_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!dq_oe && !cle && !ale));
  // R10
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int TW     = 4,
  parameter int WBW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_spare,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [3:0]        cfg_col_bits,
  input  logic [TW-1:0]     cfg_t_lo,
  input  logic [TW-1:0]     cfg_t_hi,
  input  logic [WBW-1:0]    cfg_t_wb,
  output logic              busy,
  output logic              done,
  output logic              fail,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i
);
  localparam logic [2:0] LAST_ACYC = 3'(N_ACYC - 1);

  seq_st_e           st_q, st_d;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              spare_q;
  logic [3:0]        cb_q;
  logic [2:0]        idx_q, idx_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [WBW-1:0]    wb_q, wb_d;
  logic              iss_q, iss_d;
  logic              fail_q, fail_d;
  logic [7:0]        rd_q, rd_d;

  logic              accept, bus_st, gate;
  logic              eng_start, eng_idle, eng_fin;
  cyc_kind_e         eng_kind;
  logic [7:0]        eng_byte, eng_rbyte;
  logic [4:0][7:0]   abytes;

  nand_addr_form #(.ADDR_W(ADDR_W), .CBW(4)) u_addr (
    .addr(addr_q), .spare(spare_q), .col_bits(cb_q), .cyc_bytes(abytes)
  );

  nand_bus_cyc #(.TW(TW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
    .wbyte(eng_byte), .t_lo(cfg_t_lo), .t_hi(cfg_t_hi), .dq_i(nand_dq_i),
    .idle(eng_idle), .fin(eng_fin), .rbyte(eng_rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  assign accept = (st_q == S_IDLE) && req_valid && (req_op <= 3'd4);
  assign bus_st = (st_q inside {S_CMD1, S_ADDR, S_WDATA, S_CMD2,
                                S_RDATA, S_STCMD, S_STRD});

  always_comb begin
    gate     = 1'b1;
    eng_kind = K_CMD;
    eng_byte = 8'h00;
    unique case (st_q)
      S_CMD1: unique case (op_q)
        OP_RESET: eng_byte = OPC_RESET;
        OP_RDID:  eng_byte = OPC_RDID;
        OP_PREAD: eng_byte = OPC_PREAD;
        OP_PROG:  eng_byte = OPC_PROG;
        default:  eng_byte = OPC_ERASE;
      endcase
      S_ADDR: begin
        eng_kind = K_ADDR;
        eng_byte = (op_q == OP_RDID) ? 8'h00 : abytes[idx_q];
      end
      S_WDATA: begin
        eng_kind = K_WR;
        eng_byte = wr_data;
        gate     = (rem_q != '0) && wr_valid;
      end
      S_CMD2: eng_byte = (op_q == OP_PREAD) ? OPC_PREAD2 :
                         (op_q == OP_PROG)  ? OPC_PROG2  : OPC_ERASE2;
      S_RDATA: begin
        eng_kind = K_RD;
        gate     = (rem_q != '0);
      end
      S_STCMD: eng_byte = OPC_STATUS;
      S_STRD:  eng_kind = K_RD;
      default: gate = 1'b0;
    endcase
  end

  assign eng_start = bus_st && eng_idle && !iss_q && gate;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    rem_d  = rem_q;
    wb_d   = wb_q;
    fail_d = fail_q;
    rd_d   = rd_q;
    iss_d  = eng_fin ? 1'b0 : (eng_start ? 1'b1 : iss_q);
    unique case (st_q)
      S_IDLE: if (accept) begin
        st_d   = S_CMD1;
        fail_d = 1'b0;
        idx_d  = '0;
        rem_d  = (req_op == 3'(OP_RDID)) ? LEN_W'(ID_BYTES) : req_len;
      end
      S_CMD1: if (eng_fin) begin
        st_d  = (op_q == OP_RESET) ? S_DONE : S_ADDR;
        idx_d = (op_q == OP_ERASE) ? 3'd2 : 3'd0;
      end
      S_ADDR: if (eng_fin) begin
        if (op_q == OP_RDID)          st_d = S_RDATA;
        else if (idx_q == LAST_ACYC)  st_d = (op_q == OP_PROG) ? S_WDATA : S_CMD2;
        else                          idx_d = idx_q + 3'd1;
      end
      S_WDATA: if (eng_fin)           rem_d = rem_q - LEN_W'(1);
               else if (rem_q == '0)  st_d = S_CMD2;
      S_CMD2: if (eng_fin) begin
        st_d = S_WAIT;
        wb_d = cfg_t_wb;
      end
      S_WAIT: if (wb_q == '0) st_d = (op_q == OP_PREAD) ? S_RDATA : S_STCMD;
              else            wb_d = wb_q - WBW'(1);
      S_RDATA: if (eng_fin) begin
        rd_d = eng_rbyte;
        st_d = S_RDOUT;
      end else if (rem_q == '0) st_d = S_DONE;
      S_RDOUT: if (rd_ready) begin
        rem_d = rem_q - LEN_W'(1);
        st_d  = S_RDATA;
      end
      S_STCMD: if (eng_fin) st_d = S_STRD;
      S_STRD: if (eng_fin) begin
        if (eng_rbyte[RDY_BIT]) begin
          fail_d = eng_rbyte[FAIL_BIT];
          st_d   = S_DONE;
        end else st_d = S_STCMD;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_RESET;
      addr_q  <= '0;
      spare_q <= 1'b0;
      cb_q    <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      wb_q    <= '0;
      iss_q   <= 1'b0;
      fail_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      wb_q   <= wb_d;
      iss_q  <= iss_d;
      fail_q <= fail_d;
      rd_q   <= rd_d;
      if (accept) begin
        op_q    <= op_e'(req_op);
        addr_q  <= req_addr;
        spare_q <= req_spare;
        cb_q    <= cfg_col_bits;
      end
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign fail      = fail_q;
  assign nand_ce_n = (st_q == S_IDLE);
  assign wr_ready  = (st_q == S_WDATA) && eng_idle && !iss_q && (rem_q != '0);
  assign rd_valid  = (st_q == S_RDOUT);
  assign rd_data   = rd_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(fail));
  // R5
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !nand_ce_n && nand_we_n));
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int TW     = 4;
  localparam int WBW    = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_spare;
  logic [2:0] req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [3:0] cfg_col_bits;
  logic [TW-1:0] cfg_t_lo, cfg_t_hi;
  logic [WBW-1:0] cfg_t_wb;
  logic busy, done, fail;
  logic [7:0] wr_data, rd_data, nand_dq_o, nand_dq_i;
  logic wr_valid, wr_ready, rd_valid, rd_ready;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;

  always #2 clk = ~clk;

  nand_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TW(TW), .WBW(WBW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_spare(req_spare), .req_len(req_len),
    .cfg_col_bits(cfg_col_bits), .cfg_t_lo(cfg_t_lo), .cfg_t_hi(cfg_t_hi),
    .cfg_t_wb(cfg_t_wb), .busy(busy), .done(done), .fail(fail),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] exp_log [0:255];
  logic [9:0] act_log [0:255];
  logic [7:0] exp_rd [0:63];
  logic [7:0] act_rd [0:63];
  int n_exp, n_act, n_exprd, n_actrd;
  logic [7:0] m_last_cmd;
  int m_idx, m_poll, m_poll_n;
  logic m_fail;
  logic prev_we, prev_re;
  int lo_run, exp_lo, width_err, bus_err;
  logic wb_arm;
  int wb_cnt, wb_err, exp_wb;
  int widx, n_done;
  logic done_fail;

  function automatic logic [7:0] pat(int i);
    return 8'h81 ^ 8'(i * 3);
  endfunction
  function automatic logic [7:0] mdat(int i);
    return 8'h3C + 8'(i * 5);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] k, logic [7:0] b);
    if (n_exp < 256) exp_log[n_exp] = {k, b};
    n_exp++;
  endtask

  task automatic push_rd(logic [7:0] b);
    if (n_exprd < 64) exp_rd[n_exprd] = b;
    n_exprd++;
  endtask

  task automatic build_exp(int op, logic [31:0] addr, bit spare, int len,
                           int c, int polln, bit f);
    logic [31:0] unit, col, row;
    unit = 32'd1 << c;
    col  = (addr & (unit - 32'd1)) + (spare ? unit : 32'd0);
    row  = addr >> c;
    n_exp = 0;
    n_exprd = 0;
    case (op)
      0: push(2'd0, 8'hFF);
      1: begin
        push(2'd0, 8'h90); push(2'd1, 8'h00);
        for (int i = 0; i < 5; i++) begin push(2'd3, mdat(i)); push_rd(mdat(i)); end
      end
      2, 3: begin
        push(2'd0, (op == 2) ? 8'h00 : 8'h80);
        push(2'd1, col[7:0]); push(2'd1, col[15:8]);
        push(2'd1, row[7:0]); push(2'd1, row[15:8]); push(2'd1, row[23:16]);
        if (op == 2) begin
          push(2'd0, 8'h30);
          for (int i = 0; i < len; i++) begin push(2'd3, mdat(i)); push_rd(mdat(i)); end
        end else begin
          for (int i = 0; i < len; i++) push(2'd2, pat(i));
          push(2'd0, 8'h10);
        end
      end
      default: begin
        push(2'd0, 8'h60);
        push(2'd1, row[7:0]); push(2'd1, row[15:8]); push(2'd1, row[23:16]);
        push(2'd0, 8'hD0);
      end
    endcase
    if (op >= 3) begin
      for (int i = 0; i < polln; i++) begin push(2'd0, 8'h70); push(2'd3, 8'h00); end
      push(2'd0, 8'h70); push(2'd3, 8'h20 | {7'd0, f});
    end
  endtask

  // device model, bus monitor and stream ends, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (nand_cle && nand_ale) bus_err++;
      if (!nand_we_n && !nand_re_n) bus_err++;
      if (!nand_re_n && nand_dq_oe) bus_err++;
      if (!prev_we && nand_we_n) begin
        if (n_act < 256)
          act_log[n_act] = {nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2), nand_dq_o};
        n_act++;
        if (nand_cle) begin
          m_last_cmd = nand_dq_o;
          m_idx = 0;
          if (nand_dq_o == 8'h80 || nand_dq_o == 8'h60) m_poll = 0;
          if (nand_dq_o == 8'h30 || nand_dq_o == 8'h10 || nand_dq_o == 8'hD0) begin
            wb_arm = 1'b1;
            wb_cnt = 0;
          end
        end
      end
      if (!prev_re && nand_re_n) begin
        if (n_act < 256) act_log[n_act] = {2'd3, nand_dq_i};
        n_act++;
        if (m_last_cmd == 8'h70) m_poll++;
        else m_idx++;
      end
      if (!nand_we_n || !nand_re_n) lo_run++;
      else if (lo_run != 0) begin
        if (lo_run != exp_lo) width_err++;
        lo_run = 0;
      end
      if (wb_arm) begin
        if (!nand_we_n || !nand_re_n) begin
          if (wb_cnt < exp_wb) wb_err++;
          wb_arm = 1'b0;
        end else wb_cnt++;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
      if (m_last_cmd == 8'h70)
        nand_dq_i = (m_poll < m_poll_n) ? 8'h00 : (8'h20 | {7'd0, m_fail});
      else
        nand_dq_i = mdat(m_idx);
      begin
        bit v;
        v = ($urandom % 4) != 0;
        wr_valid = v;
        if (v && wr_ready) begin
          wr_data = pat(widx);
          widx++;
        end
      end
      begin
        bit r;
        r = ($urandom % 3) != 0;
        rd_ready = r;
        if (rd_valid && r) begin
          if (n_actrd < 64) act_rd[n_actrd] = rd_data;
          n_actrd++;
        end
      end
      if (done) begin
        n_done++;
        done_fail = fail;
      end
    end
  end

  task automatic run_op(int op, logic [31:0] addr, bit spare, int len, int c,
                        int tlo, int thi, int twb, int polln, bit f, bit poke);
    string tag;
    int t;
    int bad;
    @(negedge clk);
    cfg_col_bits = 4'(c);
    cfg_t_lo = TW'(tlo);
    cfg_t_hi = TW'(thi);
    cfg_t_wb = WBW'(twb);
    m_poll_n = polln;
    m_fail = f;
    exp_lo = (tlo == 0) ? 1 : tlo;
    exp_wb = twb;
    n_act = 0; n_actrd = 0; width_err = 0; wb_err = 0; bus_err = 0;
    widx = 0; n_done = 0; done_fail = 1'bx;
    build_exp(op, addr, spare, len, c, polln, f);
    req_valid = 1'b1;
    req_op = 3'(op);
    req_addr = addr;
    req_spare = spare;
    req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (n_done == 0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (poke && t == 10) begin req_valid = 1'b1; req_op = 3'd0; end
      if (poke && t == 11) req_valid = 1'b0;
    end
    repeat (6) @(negedge clk);
    case (op)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R4 R3";
      3: tag = "R5 R3 R7";
      default: tag = "R6 R3 R7";
    endcase
    // R11 exactly one completion per request
    check(n_done == 1, "R11", "done pulses", n_done, 1);
    bad = -1;
    for (int i = 0; i < n_exp && i < 256; i++)
      if (bad < 0 && (i >= n_act || act_log[i] !== exp_log[i])) bad = i;
    check(n_act == n_exp, tag, "bus cycle count", n_act, n_exp);
    if (bad >= 0)
      check(1'b0, tag, "bus cycle {kind,byte} mismatch",
            (bad < n_act) ? int'(act_log[bad]) : -1, int'(exp_log[bad]));
    else
      check(1'b1, tag, "bus cycles", 0, 0);
    bad = -1;
    for (int i = 0; i < n_exprd && i < 64; i++)
      if (bad < 0 && (i >= n_actrd || act_rd[i] !== exp_rd[i])) bad = i;
    check(n_actrd == n_exprd && bad < 0, tag, "read stream bytes",
          (bad >= 0 && bad < n_actrd) ? int'(act_rd[bad]) : n_actrd,
          (bad >= 0) ? int'(exp_rd[bad]) : n_exprd);
    // R7 outcome from the final status byte
    check(done_fail === ((op >= 3) ? f : 1'b0), (op >= 3) ? "R7" : tag, "fail",
          int'(done_fail), (op >= 3) ? int'(f) : 0);
    // R10 strobe widths
    check(width_err == 0, "R10", "strobe low widths off", width_err, 0);
    // R8 post-confirm delay
    check(wb_err == 0, "R8", "short confirm delay", wb_err, 0);
    // R9 latch/strobe/drive exclusivity
    check(bus_err == 0, "R9", "bus overlap", bus_err, 0);
    check(busy == 1'b0 && nand_ce_n == 1'b1, "R11", "idle after done",
          int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_spare = 1'b0; req_len = '0;
    cfg_col_bits = 4'd11; cfg_t_lo = TW'(1); cfg_t_hi = TW'(1); cfg_t_wb = '0;
    wr_data = '0; wr_valid = 1'b0; rd_ready = 1'b0; nand_dq_i = '0;
    m_last_cmd = '0; m_idx = 0; m_poll = 0; m_poll_n = 0; m_fail = 1'b0;
    prev_we = 1'b1; prev_re = 1'b1; lo_run = 0; exp_lo = 1;
    width_err = 0; bus_err = 0; wb_arm = 1'b0; wb_cnt = 0; wb_err = 0; exp_wb = 0;
    widx = 0; n_done = 0; done_fail = 1'b0; n_exp = 0; n_act = 0;
    n_exprd = 0; n_actrd = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(nand_ce_n && nand_we_n && nand_re_n, "R12", "strobes/ce in reset",
          int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    check(!nand_cle && !nand_ale && !busy && !done, "R12", "latches/busy in reset",
          int'({nand_cle, nand_ale, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(nand_ce_n && !busy && nand_we_n, "R12", "state after reset",
          int'({nand_ce_n, busy, nand_we_n}), 5);

    run_op(0, 32'h0, 1'b0, 0, 11, 1, 1, 0, 0, 1'b0, 1'b0);
    run_op(1, 32'h0, 1'b0, 0, 11, 0, 0, 2, 0, 1'b0, 1'b0);
    run_op(2, 32'h0012_3456, 1'b0, 4, 11, 2, 1, 3, 0, 1'b0, 1'b0);
    run_op(2, 32'h0ABC_0FFF, 1'b1, 0, 12, 1, 2, 0, 0, 1'b0, 1'b0);
    run_op(3, 32'h1234_5678, 1'b1, 3, 10, 3, 2, 4, 2, 1'b0, 1'b1);
    run_op(4, 32'h0F0E_0D0C, 1'b0, 0, 11, 1, 1, 1, 0, 1'b1, 1'b0);
    run_op(3, 32'h0000_07FF, 1'b0, 0, 15, 2, 3, 5, 1, 1'b1, 1'b0);

    // R11 unknown operation code is ignored
    begin
      int nd;
      @(negedge clk);
      n_act = 0; n_done = 0;
      req_valid = 1'b1; req_op = 3'd6;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);
      nd = n_done;
      check(nd == 0 && n_act == 0 && !busy, "R11", "unknown op activity",
            nd + n_act, 0);
    end

    for (int k = 0; k < 30; k++) begin
      run_op(int'($urandom % 5), $urandom, 1'($urandom % 2),
             int'($urandom % 9), 8 + int'($urandom % 8),
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 7),
             int'($urandom % 4), 1'($urandom % 2), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule